// File: doc/BRIEF.md
# Pluggable Module Management Controller

This block is the module-side logic behind a pluggable transceiver's low-speed management pins. It filters the host's active-low reset pin, selects between low-power and high-power operation, gates register access on the host's select line, and drives the active-low interrupt output. The two-wire serial link is assumed to be decoded elsewhere. The block sees each transaction as a single-cycle access on a simple port that carries an address, a write enable and write data, and returns read data.

After power-up, or after a reset pin pulse that is long enough, the block runs an initialisation count. During this count a data-not-ready flag stays set. At the end the block clears the flag and raises a reset-complete interrupt, which the host acknowledges by reading the status byte. Fault events from the rest of the module, such as temperature alarms, are latched into a flag byte. Each latched flag pulls the interrupt low unless its mask bit is set. A read of the flag byte clears the flags. High-power operation is granted only after initialisation, and comes either from the low-power pin or from override bits in a control byte.

Top module: `pm_mgmt_ctrl`

## Requirements
- R1: After `rst`, `irq_n` is 1, `hipower` is 0, `rd_valid` is 0, and the status byte (address 2) reads 0x01, with bit 0 as the data-not-ready flag.
- R2: Data-not-ready stays 1 for INIT_CYC cycles after any reset and then clears. On completion `irq_n` goes low with no reset pin pulse needed, and the status byte then reads 0x00.
- R3: A read of the status byte while data-not-ready is 0 acknowledges completion. `irq_n` returns to 1 on the second clock edge after the read, unless an unmasked flag is pending.
- R4: If `mod_reset_n` is held low for at least MIN_RST_CYC cycles, the module resets fully. The mask and power-control bytes return to 0x00, latched flags clear, `hipower` drops, `irq_n` releases, and initialisation restarts with data-not-ready set to 1.
- R5: A low pulse on `mod_reset_n` shorter than MIN_RST_CYC cycles has no effect on registers, status or `hipower`.
- R6: While data-not-ready is 1, writes are ignored, and reads of the flag (3), mask (4) and power-control (93) bytes return 0x00.
- R7: While `sel_n` is 1, an access produces no `rd_valid` and a write changes nothing.
- R8: `hipower` is 1 only when data-not-ready is 0 and low power is not selected. Low power is selected by bit 1 of byte 93 when bit 0 of byte 93 (override) is 1. Otherwise `lp_req` = 1 selects it. `lp_req` reaches `hipower` within three edges. A byte 93 write reaches `hipower` on the edge after the write.
- R9: An `alarm_ev[i]` pulse while data-not-ready is 0 sets bit i of byte 3. A read of byte 3 returns the flags and clears them. Events while data-not-ready is 1 are not latched.
- R10: `irq_n` is 0 while any byte 3 flag is set whose byte 4 mask bit is 0. A mask bit of 1 suppresses that flag's interrupt.
- R11: Read data and `rd_valid` appear one cycle after the access cycle. Unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| mod_reset_n | input | 1 | Host reset request pin, active low |
| lp_req | input | 1 | Host low-power request pin, 1 = low power |
| sel_n | input | 1 | Host select, active low; gates register access |
| acc_valid | input | 1 | Decoded register access strobe |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Register byte address |
| acc_wdata | input | 8 | Write data |
| alarm_ev | input | N_ALARM | Fault event inputs, one per flag bit |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| irq_n | output | 1 | Interrupt, active low (open-drain pull-down request) |
| hipower | output | 1 | High-power operation enable |

## Verification
A stuck or miscounted initialisation counter shows at `irq_n`: the reset-complete interrupt comes early or late, or never, relative to INIT_CYC. A status read shows the same fault within one cycle. A reset filter that counts wrongly either resets the module on a short pulse, which loses the mask byte and drops `hipower`, or misses a long one. A flag or mask bit that is wrong appears on `irq_n` two edges after the event, and on the next read of byte 3. Errors in power selection appear on `hipower` within three edges of the pin or register change.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int AW = 8;
  localparam int DW = 8;

  // Byte addresses decoded by the host side
  localparam logic [AW-1:0] A_STATUS = 8'd2;
  localparam logic [AW-1:0] A_FLAGS  = 8'd3;
  localparam logic [AW-1:0] A_MASK   = 8'd4;
  localparam logic [AW-1:0] A_PWRCTL = 8'd93;

  // Power control byte: bit0 = override, bit1 = forced low power
  typedef struct packed {
    logic lp_set;
    logic lp_ovr;
  } pwrctl_t;
endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pm_rst_filter.sv
module pm_rst_filter #(
  parameter int MIN_CYC = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,   // synchronised pin level, active low
  output logic hold
);
  localparam int CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] MIN_V = CW'(MIN_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (lvl)           cnt <= '0;
    else if (cnt != MIN_V)  cnt <= cnt + 1'b1;
  end

  assign hold = (cnt == MIN_V);

  // R5: the reset hold can only follow a sampled low pin level
  p_hold_after_low_r5: assert property (@(posedge clk) disable iff (rst)
    hold |-> $past(!lvl));
endmodule

// File: rtl/pm_init_seq.sv
module pm_init_seq #(
  parameter int INIT_CYC = 250
) (
  input  logic clk,
  input  logic srst,
  input  logic clr_done,
  output logic dnr,
  output logic done
);
  localparam int CW = $clog2(INIT_CYC + 1);
  localparam logic [CW-1:0] INIT_V = CW'(INIT_CYC);

  logic [CW-1:0] icnt;

  always_ff @(posedge clk) begin
    if (srst) begin
      icnt <= INIT_V;
      dnr  <= 1'b1;
      done <= 1'b0;
    end else begin
      if (icnt != '0) icnt <= icnt - 1'b1;
      if (icnt == CW'(1)) begin
        dnr  <= 1'b0;
        done <= 1'b1;
      end else if (clr_done) begin
        done <= 1'b0;
      end
    end
  end

  // R2: ready transition always raises the completion interrupt source
  p_ready_raises_done_r2: assert property (@(posedge clk) disable iff (srst)
    $fell(dnr) |-> done);
endmodule

// File: rtl/pm_alarm_bank.sv
module pm_alarm_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         srst,
  input  logic         en,
  input  logic [N-1:0] ev,
  input  logic         clr,
  input  logic [N-1:0] mask,
  output logic [N-1:0] flags,
  output logic         pend
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (srst)              flags[i] <= 1'b0;
      else if (en && ev[i])  flags[i] <= 1'b1;
      else if (clr)          flags[i] <= 1'b0;
    end

    // R9: an enabled event is always latched
    p_event_latched_r9: assert property (@(posedge clk) disable iff (srst)
      (en && ev[i]) |=> flags[i]);
  end

  assign pend = |(flags & ~mask);
endmodule

// File: rtl/pm_mgmt_ctrl.sv
module pm_mgmt_ctrl
  import pm_pkg::*;
#(
  parameter int MIN_RST_CYC = 32,
  parameter int INIT_CYC = 250,
  parameter int N_ALARM = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mod_reset_n,
  input  logic               lp_req,
  input  logic               sel_n,
  input  logic               acc_valid,
  input  logic               acc_we,
  input  logic [AW-1:0]      acc_addr,
  input  logic [DW-1:0]      acc_wdata,
  input  logic [N_ALARM-1:0] alarm_ev,
  output logic               rd_valid,
  output logic [DW-1:0]      rd_data,
  output logic               irq_n,
  output logic               hipower
);
  initial assert (N_ALARM >= 1 && N_ALARM <= DW);

  logic [1:0] pins_s;
  logic       rstpin_s, lp_s;
  logic       hold, srst;
  logic       dnr, done, pend;
  logic       acc, rd, wr, clr_flags, clr_done;
  logic [N_ALARM-1:0] mask_q, flags;
  pwrctl_t    pwr_q;
  logic [DW-1:0] rdata_c;
  logic       low_pwr;
  logic       unused_wdata;

  pm_sync #(.STAGES(SYNC_STAGES), .WIDTH(2), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst(rst), .d({mod_reset_n, lp_req}), .q(pins_s)
  );
  assign rstpin_s = pins_s[1];
  assign lp_s     = pins_s[0];

  pm_rst_filter #(.MIN_CYC(MIN_RST_CYC)) u_filt (
    .clk(clk), .rst(rst), .lvl(rstpin_s), .hold(hold)
  );

  assign srst = rst | hold;

  // Access decode
  assign acc       = acc_valid & ~sel_n;
  assign rd        = acc & ~acc_we;
  assign wr        = acc & acc_we & ~dnr;
  assign clr_flags = rd & ~dnr & (acc_addr == A_FLAGS);
  assign clr_done  = rd & ~dnr & (acc_addr == A_STATUS);

  pm_init_seq #(.INIT_CYC(INIT_CYC)) u_init (
    .clk(clk), .srst(srst), .clr_done(clr_done), .dnr(dnr), .done(done)
  );

  pm_alarm_bank #(.N(N_ALARM)) u_alarm (
    .clk(clk), .srst(srst), .en(~dnr), .ev(alarm_ev), .clr(clr_flags),
    .mask(mask_q), .flags(flags), .pend(pend)
  );

  // Writable bytes
  always_ff @(posedge clk) begin
    if (srst) begin
      mask_q <= '0;
      pwr_q  <= '0;
    end else if (wr) begin
      if (acc_addr == A_MASK)   mask_q <= acc_wdata[N_ALARM-1:0];
      if (acc_addr == A_PWRCTL) pwr_q  <= pwrctl_t'(acc_wdata[1:0]);
    end
  end
  assign unused_wdata = ^acc_wdata;

  // Read mux: defaults are returned while not ready
  always_comb begin
    rdata_c = '0;
    case (acc_addr)
      A_STATUS: rdata_c[0] = dnr;
      A_FLAGS:  if (!dnr) rdata_c[N_ALARM-1:0] = flags;
      A_MASK:   if (!dnr) rdata_c[N_ALARM-1:0] = mask_q;
      A_PWRCTL: if (!dnr) rdata_c[1:0] = pwr_q;
      default:  rdata_c = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd;
      if (rd) rd_data <= rdata_c;
    end
  end

  // Power mode and interrupt outputs
  assign low_pwr = pwr_q.lp_ovr ? pwr_q.lp_set : lp_s;

  always_ff @(posedge clk) begin
    if (srst) begin
      hipower <= 1'b0;
      irq_n   <= 1'b1;
    end else begin
      hipower <= ~dnr & ~low_pwr;
      irq_n   <= ~(done | pend);
    end
  end

  // R7: unselected accesses never produce read data
  p_unselected_quiet_r7: assert property (@(posedge clk) disable iff (srst)
    (acc_valid && sel_n) |=> !rd_valid);

  // R4: a filtered pin reset leaves the module not ready and quiet
  p_pin_reset_r4: assert property (@(posedge clk) disable iff (rst)
    hold |=> (dnr && !hipower && irq_n));

  // R8: no high power while initialising
  p_no_high_power_init_r8: assert property (@(posedge clk) disable iff (srst)
    dnr |=> !hipower);

  // R2: completion source drives the interrupt pin low
  p_done_irq_r2: assert property (@(posedge clk) disable iff (srst)
    done |=> !irq_n);

  // R6: mask byte is locked while not ready
  p_mask_locked_r6: assert property (@(posedge clk) disable iff (srst)
    dnr |=> $stable(mask_q));
endmodule

// File: tb/tb_pm_mgmt_ctrl.sv
module tb_pm_mgmt_ctrl;
  localparam int MINR = 8;
  localparam int INIT = 16;
  localparam int NA = 4;

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_AL = 2'd2, OP_IRQ = 2'd3;
  localparam int NV = 16;
  // {op, addr, wdata, expected, requirement number}
  localparam logic [29:0] VEC [NV] = '{
    {OP_RD,  8'd93,   8'h00, 8'h00, 4'd6},
    {OP_RD,  8'd4,    8'h00, 8'h00, 4'd6},
    {OP_WR,  8'd4,    8'h0A, 8'h00, 4'd10},
    {OP_RD,  8'd4,    8'h00, 8'h0A, 4'd10},
    {OP_AL,  8'd0,    8'h01, 8'h00, 4'd9},
    {OP_IRQ, 8'd0,    8'h00, 8'h00, 4'd10},
    {OP_RD,  8'd3,    8'h00, 8'h01, 4'd9},
    {OP_IRQ, 8'd0,    8'h00, 8'h01, 4'd10},
    {OP_AL,  8'd0,    8'h02, 8'h00, 4'd9},
    {OP_IRQ, 8'd0,    8'h00, 8'h01, 4'd10},
    {OP_RD,  8'd3,    8'h00, 8'h02, 4'd9},
    {OP_RD,  8'd3,    8'h00, 8'h00, 4'd9},
    {OP_WR,  8'd93,   8'h03, 8'h00, 4'd8},
    {OP_RD,  8'd93,   8'h00, 8'h03, 4'd8},
    {OP_RD,  8'h55,   8'h00, 8'h00, 4'd11},
    {OP_WR,  8'd93,   8'h01, 8'h00, 4'd8}
  };

  logic clk = 1'b0;
  logic rst, mod_reset_n, lp_req, sel_n, acc_valid, acc_we;
  logic [7:0] acc_addr, acc_wdata;
  logic [NA-1:0] alarm_ev;
  logic rd_valid, irq_n, hipower;
  logic [7:0] rd_data;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pm_mgmt_ctrl #(.MIN_RST_CYC(MINR), .INIT_CYC(INIT), .N_ALARM(NA)) dut (
    .clk(clk), .rst(rst), .mod_reset_n(mod_reset_n), .lp_req(lp_req),
    .sel_n(sel_n), .acc_valid(acc_valid), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .alarm_ev(alarm_ev),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq_n(irq_n), .hipower(hipower)
  );

  function automatic string rname(input logic [3:0] n);
    case (n)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      4'd10: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  // Single access; returns at the falling edge after the sampling edge
  task automatic access(input logic we, input logic [7:0] a, input logic [7:0] d,
                        input logic sel);
    sel_n = sel; acc_valid = 1'b1; acc_we = we; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_we = 1'b0; sel_n = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    access(1'b0, a, 8'h00, 1'b0);
    chk(req, {7'b0, rd_valid}, 8'h01);
    chk(req, rd_data, exp);
  endtask

  task automatic pulse_alarm(input logic [NA-1:0] v);
    alarm_ev = v;
    @(negedge clk);
    alarm_ev = '0;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1'b1; mod_reset_n = 1'b1; lp_req = 1'b1; sel_n = 1'b0;
    acc_valid = 1'b0; acc_we = 1'b0; acc_addr = '0; acc_wdata = '0; alarm_ev = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1", {7'b0, irq_n}, 8'h01);
    chk("R1", {7'b0, hipower}, 8'h00);
    chk("R1", {7'b0, rd_valid}, 8'h00);
    rd_chk("R1", 8'd2, 8'h01);
    // R6 write ignored during initialisation
    access(1'b1, 8'd93, 8'h01, 1'b0);
    rd_chk("R6", 8'd93, 8'h00);
    chk("R6", {7'b0, hipower}, 8'h00);
    chk("R2", {7'b0, irq_n}, 8'h01);

    // R2 completion on its own
    repeat (INIT + 2) @(negedge clk);
    chk("R2", {7'b0, irq_n}, 8'h00);
    rd_chk("R2", 8'd2, 8'h00);
    chk("R3", {7'b0, irq_n}, 8'h00);
    @(negedge clk);
    chk("R3", {7'b0, irq_n}, 8'h01);

    // R7 unselected accesses
    access(1'b0, 8'd2, 8'h00, 1'b1);
    chk("R7", {7'b0, rd_valid}, 8'h00);
    access(1'b1, 8'd4, 8'h0F, 1'b1);
    rd_chk("R7", 8'd4, 8'h00);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][29:28])
        OP_WR:  access(1'b1, VEC[i][27:20], VEC[i][19:12], 1'b0);
        OP_RD:  rd_chk(rname(VEC[i][3:0]), VEC[i][27:20], VEC[i][11:4]);
        OP_AL:  pulse_alarm(VEC[i][12+NA-1:12]);
        default: begin
          @(negedge clk);
          chk(rname(VEC[i][3:0]), {7'b0, irq_n}, VEC[i][11:4]);
        end
      endcase
    end

    // R8 power selection (override 1, set 0 was just written)
    @(negedge clk);
    chk("R8", {7'b0, hipower}, 8'h01);
    access(1'b1, 8'd93, 8'h03, 1'b0);
    @(negedge clk);
    chk("R8", {7'b0, hipower}, 8'h00);
    access(1'b1, 8'd93, 8'h00, 1'b0);
    @(negedge clk);
    chk("R8", {7'b0, hipower}, 8'h00);
    lp_req = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8", {7'b0, hipower}, 8'h01);
    lp_req = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8", {7'b0, hipower}, 8'h00);
    lp_req = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8", {7'b0, hipower}, 8'h01);

    // R5 short reset pulse ignored
    mod_reset_n = 1'b0;
    repeat (MINR - 1) @(negedge clk);
    mod_reset_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5", {7'b0, hipower}, 8'h01);
    rd_chk("R5", 8'd4, 8'h0A);
    rd_chk("R5", 8'd2, 8'h00);

    // R4 long reset pulse
    mod_reset_n = 1'b0;
    repeat (MINR + 2) @(negedge clk);
    mod_reset_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R4", {7'b0, hipower}, 8'h00);
    chk("R4", {7'b0, irq_n}, 8'h01);
    rd_chk("R4", 8'd2, 8'h01);
    pulse_alarm(4'h1);
    repeat (INIT + 2) @(negedge clk);
    chk("R2", {7'b0, irq_n}, 8'h00);
    rd_chk("R9", 8'd3, 8'h00);
    rd_chk("R4", 8'd4, 8'h00);
    rd_chk("R4", 8'd93, 8'h00);
    chk("R8", {7'b0, hipower}, 8'h01);

    finish_run();
  end
endmodule